// File: doc/BRIEF.md
# Eight-Channel Compare/Capture Timer with Access-Side-Effect Flag Clearing

The block is an eight-channel timer built around a free-running 16-bit up counter. A power-of-two prescaler gates the counter. Each channel is either an output compare channel or an input capture channel. An output compare channel raises its flag when the counter steps onto the channel's value, and then drives its pin with a programmed action. An input capture channel latches the counter on a rising edge of its input and raises its flag. A single overflow flag marks each wrap of the counter from all ones to zero.

Three controls shape the behaviour. The first is a stop-in-freeze control, which halts counting while the debug freeze input is high. The second is a fast-clear mode. In this mode the flags clear as a side effect of ordinary accesses to the channel and counter registers, and writing ones to the flag registers has no effect. The third is a per-channel toggle-on-overflow enable, which inverts an output compare pin on every counter wrap. The last channel acts as an override channel: when it fires, it drives the pins of the channels selected by a mask with the matching data bits.

Software reaches the block through a synchronous register port with address, write enable, read strobe and write data. Read data is combinational from the address.

Top module: `tmr_oc8`

## Requirements
- R1: After reset, all control bits (run, freeze-stop, fast-clear, prescale, direction, toggle-on-overflow, actions, override mask and data) are zero. The counter, all flags and all pins are also zero.
- R2: While run (control bit 0) is set, the counter advances once every 2^s clock cycles, where s is control bits 6:4. A write to the counter register (address 7) loads the counter and restarts the prescaler.
- R3: When freeze-stop (control bit 1) and freeze_i are both high, the counter holds. When freeze-stop is low, the counter keeps counting even while freeze_i is high.
- R4: An output channel (direction bit 1 at address 1) whose register (address 16+i) equals the value the counter steps onto sets flag i. It then applies its action, taken from address 4 bits 2i+1:2i, where 0 means none, 1 toggle, 2 clear and 3 set. Writing a one to bit i at address 2 forces the action without setting the flag.
- R5: On a rising edge of cap_i[i], an input channel latches the current counter value into its register and sets flag i.
- R6: With fast-clear (control bit 2) low, writing a one to a bit of the channel flag register (address 8) or the overflow flag register (address 9, bit 0) clears that flag, and writing a zero leaves it unchanged. With fast-clear high, these writes have no effect.
- R7: With fast-clear high, reading an input channel's register or writing an output channel's register clears that channel's flag. Reading the flag register does not clear flags.
- R8: With fast-clear high, any read or write of the counter register clears the overflow flag.
- R9: A counter step from all ones to zero sets the overflow flag. It also inverts the pin of every output channel whose toggle-on-overflow bit (address 3) is set.
- R10: Toggle-on-overflow has no effect on input channels. Their pins (read at address 10) never change.
- R11: On a given cycle, an override from channel 7 (its match or force) on a masked pin (mask at address 5, data at address 6) has the highest priority. Toggle-on-overflow comes next. The channel's own match or force action comes last.
- R12: When a flag-setting event and a flag-clearing access fall on the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (drives the access side effects) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 8 | Capture inputs, one per channel |
| freeze_i | input | 1 | Debug freeze request |
| pins_o | output | 8 | Compare pin outputs |

## Verification
The bench targets the prescaler count after a fixed number of enabled cycles. A design that is off by one edge at the run-enable boundary would read back a different count. A toggle-on-overflow request lands on the same edge as a forced clear. A design with the wrong priority would leave the pin low instead of toggling it. The overflow also lands on the same edge as a channel 7 override of two masked pins. A design that lets the toggle win would leave pin 0 low. A capture edge coincides with a fast-clear read of the same register. A design where clear beats set would lose the flag. The bench also checks that write-one-to-clear stops working in fast-clear mode, and that an enabled toggle-on-overflow leaves capture pins untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TOG  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_SET  = 2'd3
  } oc_act_e;

  localparam int A_CTRL  = 0;
  localparam int A_IOSEL = 1;
  localparam int A_FORCE = 2;
  localparam int A_TOV   = 3;
  localparam int A_ACT   = 4;
  localparam int A_OMASK = 5;
  localparam int A_ODATA = 6;
  localparam int A_CNT   = 7;
  localparam int A_FLAG  = 8;
  localparam int A_OVF   = 9;
  localparam int A_PINS  = 10;
  localparam int A_CH    = 16;

  localparam int CTL_RUN  = 0;
  localparam int CTL_FRZ  = 1;
  localparam int CTL_FAST = 2;
  localparam int CTL_PS   = 4;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [PSW-1:0] psel_i,
  input  logic           wr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  cnt_o,
  output logic [CW-1:0]  nxt_o,
  output logic           tick_o,
  output logic           wrap_o
);
  localparam int PW = (1 << PSW) - 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pmask;
  logic [CW-1:0] cnt_q;

  assign pmask  = PW'((1 << psel_i) - 1);
  assign tick_o = run_i && ((pcnt_q & pmask) == pmask);
  assign nxt_o  = cnt_q + 1'b1;
  assign wrap_o = tick_o && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (wr_i) begin
      pcnt_q <= '0;
      cnt_q  <= wdata_i;
    end else begin
      if (run_i)  pcnt_q <= pcnt_q + 1'b1;
      if (tick_o) cnt_q  <= nxt_o;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          is_out_i,
  input  oc_act_e       act_i,
  input  logic          reg_wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] nxt_i,
  input  logic          cap_in_i,
  input  logic          force_i,
  input  logic          tov_en_i,
  input  logic          wrap_i,
  input  logic          ovr_evt_i,
  input  logic          ovr_mask_i,
  input  logic          ovr_data_i,
  input  logic          clr_i,
  output logic [CW-1:0] val_o,
  output logic          flag_o,
  output logic          set_o,
  output logic          match_o,
  output logic          pin_o
);
  logic [CW-1:0] val_q;
  logic          prev_q, flag_q, pin_q;
  logic          cap_edge;

  assign cap_edge = !is_out_i && cap_in_i && !prev_q;
  assign match_o  = is_out_i && tick_i && (nxt_i == val_q);
  assign set_o    = match_o || cap_edge;
  assign val_o    = val_q;
  assign flag_o   = flag_q;
  assign pin_o    = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= cap_in_i;
      if (reg_wr_i)      val_q <= wdata_i;
      else if (cap_edge) val_q <= cnt_i;
      // set beats a same-cycle clear
      if (set_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (is_out_i) begin
      if (ovr_evt_i && ovr_mask_i) begin
        pin_q <= ovr_data_i;
      end else if (tov_en_i && wrap_i) begin
        pin_q <= ~pin_q;
      end else if (match_o || force_i) begin
        unique case (act_i)
          ACT_TOG: pin_q <= ~pin_q;
          ACT_CLR: pin_q <= 1'b0;
          ACT_SET: pin_q <= 1'b1;
          default: pin_q <= pin_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_oc8.sv
module tmr_oc8
  import tmr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 6,
  parameter int PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  input  logic [NCH-1:0] cap_i,
  input  logic           freeze_i,
  output logic [NCH-1:0] pins_o
);
  localparam int ACTW = 2 * NCH;
  localparam int OVR  = NCH - 1;

  logic           run_q, frz_q, fast_q;
  logic [PSW-1:0] psel_q;
  logic [NCH-1:0] io_sel_q, tov_q, omask_q, odata_q;
  logic [ACTW-1:0] act_q;
  logic           ovf_q;

  logic           run, cnt_wr, cnt_acc, tick, wrap, ovr_evt;
  logic [CW-1:0]  cnt, nxt;
  logic [NCH-1:0] ch_flag, ch_set, ch_match, ch_force, ch_clr, ch_wr, ch_rd;
  logic [CW-1:0]  ch_val [NCH];

  logic wr_flag, wr_ovf, wr_force;
  assign wr_flag  = we_i && (addr_i == AW'(A_FLAG));
  assign wr_ovf   = we_i && (addr_i == AW'(A_OVF));
  assign wr_force = we_i && (addr_i == AW'(A_FORCE));
  assign cnt_wr   = we_i && (addr_i == AW'(A_CNT));
  assign cnt_acc  = (we_i || re_i) && (addr_i == AW'(A_CNT));

  assign run = run_q && !(frz_q && freeze_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      frz_q    <= 1'b0;
      fast_q   <= 1'b0;
      psel_q   <= '0;
      io_sel_q <= '0;
      tov_q    <= '0;
      act_q    <= '0;
      omask_q  <= '0;
      odata_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        AW'(A_CTRL): begin
          run_q  <= wdata_i[CTL_RUN];
          frz_q  <= wdata_i[CTL_FRZ];
          fast_q <= wdata_i[CTL_FAST];
          psel_q <= wdata_i[CTL_PS +: PSW];
        end
        AW'(A_IOSEL): io_sel_q <= wdata_i[NCH-1:0];
        AW'(A_TOV):   tov_q    <= wdata_i[NCH-1:0];
        AW'(A_ACT):   act_q    <= wdata_i[ACTW-1:0];
        AW'(A_OMASK): omask_q  <= wdata_i[NCH-1:0];
        AW'(A_ODATA): odata_q  <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  // overflow flag: set wins over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
    end else if (wrap) begin
      ovf_q <= 1'b1;
    end else if (fast_q ? cnt_acc : (wr_ovf && wdata_i[0])) begin
      ovf_q <= 1'b0;
    end
  end

  tmr_count #(.CW(CW), .PSW(PSW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .psel_i  (psel_q),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .nxt_o   (nxt),
    .tick_o  (tick),
    .wrap_o  (wrap)
  );

  assign ovr_evt = io_sel_q[OVR] && (ch_match[OVR] || ch_force[OVR]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_wr[i]    = we_i && (addr_i == AW'(A_CH + i));
    assign ch_rd[i]    = re_i && (addr_i == AW'(A_CH + i));
    assign ch_force[i] = wr_force && wdata_i[i] && io_sel_q[i];
    assign ch_clr[i]   = fast_q ? ((ch_rd[i] && !io_sel_q[i]) || (ch_wr[i] && io_sel_q[i]))
                                : (wr_flag && wdata_i[i]);

    tmr_chan #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .is_out_i   (io_sel_q[i]),
      .act_i      (oc_act_e'(act_q[2*i +: 2])),
      .reg_wr_i   (ch_wr[i]),
      .wdata_i    (wdata_i),
      .tick_i     (tick),
      .cnt_i      (cnt),
      .nxt_i      (nxt),
      .cap_in_i   (cap_i[i]),
      .force_i    (ch_force[i]),
      .tov_en_i   (tov_q[i]),
      .wrap_i     (wrap),
      .ovr_evt_i  (ovr_evt),
      .ovr_mask_i (omask_q[i]),
      .ovr_data_i (odata_q[i]),
      .clr_i      (ch_clr[i]),
      .val_o      (ch_val[i]),
      .flag_o     (ch_flag[i]),
      .set_o      (ch_set[i]),
      .match_o    (ch_match[i]),
      .pin_o      (pins_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(A_CTRL): begin
        rdata_o[CTL_RUN]       = run_q;
        rdata_o[CTL_FRZ]       = frz_q;
        rdata_o[CTL_FAST]      = fast_q;
        rdata_o[CTL_PS +: PSW] = psel_q;
      end
      AW'(A_IOSEL): rdata_o[NCH-1:0]  = io_sel_q;
      AW'(A_TOV):   rdata_o[NCH-1:0]  = tov_q;
      AW'(A_ACT):   rdata_o[ACTW-1:0] = act_q;
      AW'(A_OMASK): rdata_o[NCH-1:0]  = omask_q;
      AW'(A_ODATA): rdata_o[NCH-1:0]  = odata_q;
      AW'(A_CNT):   rdata_o           = cnt;
      AW'(A_FLAG):  rdata_o[NCH-1:0]  = ch_flag;
      AW'(A_OVF):   rdata_o[0]        = ovf_q;
      AW'(A_PINS):  rdata_o[NCH-1:0]  = pins_o;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (addr_i == AW'(A_CH + i)) rdata_o = ch_val[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_oc8_chk.sv
module tmr_oc8_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [CW-1:0]  cnt_i,
  input logic           tick_i,
  input logic           cnt_wr_i,
  input logic           run_en_i,
  input logic           frz_en_i,
  input logic           freeze_i,
  input logic [NCH-1:0] ch_set_i,
  input logic [NCH-1:0] ch_flag_i,
  input logic           wrap_i,
  input logic           ovf_i,
  input logic [NCH-1:0] pins_i,
  input logic [NCH-1:0] io_sel_i
);
  p_tick_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i) |=> (cnt_i == CW'($past(cnt_i) + 1'b1)));

  p_freeze_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && frz_en_i && freeze_i && !cnt_wr_i) |=> $stable(cnt_i));

  // R4, R5: an event raises its flag
  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_set_i != '0) |=> ((ch_flag_i & $past(ch_set_i)) == $past(ch_set_i)));

  p_wrap_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_i);

  p_cap_pin_still_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pins_i ^ $past(pins_i)) & ~$past(io_sel_i)) == '0);
endmodule

bind tmr_oc8 tmr_oc8_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt),
  .tick_i    (tick),
  .cnt_wr_i  (cnt_wr),
  .run_en_i  (run_q),
  .frz_en_i  (frz_q),
  .freeze_i  (freeze_i),
  .ch_set_i  (ch_set),
  .ch_flag_i (ch_flag),
  .wrap_i    (wrap),
  .ovf_i     (ovf_q),
  .pins_i    (pins_o),
  .io_sel_i  (io_sel_q)
);

// File: tb/sim_tmr_oc8.sv
module sim_tmr_oc8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cap = '0;
  logic        freeze = 1'b0;
  logic [7:0]  pins;

  int n_vec = 0, n_bad = 0;
  logic [15:0] q_exp [$];
  logic [5:0]  q_adr [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  tmr_oc8 u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .freeze_i(freeze), .pins_o(pins)
  );

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    addr = 6'(a); wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  // driver: push expected item, issue the read strobe for one cycle
  task automatic rd(input int a, input logic [15:0] e, input string tag);
    q_exp.push_back(e); q_adr.push_back(6'(a)); q_tag.push_back(tag);
    addr = 6'(a); re = 1'b1;
    @(posedge clk); #1;
    re = 1'b0;
  endtask

  // monitor: compare at the falling edge while a read is active
  always @(negedge clk) begin
    if (re && rst_n) begin
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read at %0d with empty queue act=%h exp=none", addr, rdata);
      end else begin
        logic [15:0] e;
        logic [5:0]  a;
        string t;
        e = q_exp.pop_front(); a = q_adr.pop_front(); t = q_tag.pop_front();
        n_vec++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: addr %0d act=%h exp=%h", t, a, rdata, e);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #2ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(0,  16'h0000, "R1 ctrl");
    rd(7,  16'h0000, "R1 counter");
    rd(8,  16'h0000, "R1 flags");
    rd(9,  16'h0000, "R1 ovf");
    rd(10, 16'h0000, "R1 pins");
    rd(3,  16'h0000, "R1 tov");
    rd(4,  16'h0000, "R1 actions");
    // R2 prescale by 4: 12 running edges -> 3 ticks
    wr(7, 16'h0000);
    wr(0, 16'h0021);
    idle(11);
    wr(0, 16'h0000);
    rd(7, 16'd3, "R2 prescale div4");
    // R3 freeze stop halts counter
    freeze = 1'b1;
    wr(7, 16'd100);
    wr(0, 16'h0003);
    idle(5);
    wr(0, 16'h0000);
    rd(7, 16'd100, "R3 freeze halt");
    // R3 freeze without stop keeps counting: 5 ticks
    wr(7, 16'h0000);
    wr(0, 16'h0001);
    idle(4);
    wr(0, 16'h0000);
    rd(7, 16'd5, "R3 freeze ignored");
    freeze = 1'b0;
    // R4 compare match ch0 = 5, action set
    wr(1, 16'h0001);
    wr(4, 16'h0003);
    wr(16, 16'd5);
    wr(7, 16'h0000);
    wr(0, 16'h0001);
    idle(9);
    wr(0, 16'h0000);
    rd(8,  16'h0001, "R4 match flag");
    rd(10, 16'h0001, "R4 match pin set");
    rd(7,  16'd10,   "R2 counter div1");
    // R6 normal write-one-to-clear
    wr(8, 16'h0000);
    rd(8, 16'h0001, "R6 write zero keeps flag");
    wr(8, 16'h0001);
    rd(8, 16'h0000, "R6 write one clears");
    // R5 capture on ch1
    wr(7, 16'h1234);
    cap = 8'h02;
    idle(1);
    rd(17, 16'h1234, "R5 capture value");
    rd(8,  16'h0002, "R5 capture flag, R7 no clear when slow");
    // R6 fast mode ignores write-one
    wr(0, 16'h0004);
    wr(8, 16'h0002);
    rd(8, 16'h0002, "R6 fast ignores w1c");
    // R7 read capture register clears
    rd(17, 16'h1234, "R7 capture read");
    rd(8,  16'h0000, "R7 read cleared flag");
    // R7 write compare register clears
    wr(7, 16'h0000);
    wr(0, 16'h0005);
    idle(9);
    wr(0, 16'h0004);
    rd(8, 16'h0001, "R7 flag set before write");
    wr(16, 16'd5);
    rd(8, 16'h0000, "R7 compare write cleared flag");
    // R9 overflow toggles ch0, R10 ch1 untouched
    wr(0, 16'h0000);
    wr(4, 16'h0000);
    wr(3, 16'h0003);
    wr(7, 16'hFFFE);
    wr(0, 16'h0001);
    idle(2);
    wr(0, 16'h0000);
    rd(9,  16'h0001, "R9 overflow flag");
    rd(10, 16'h0000, "R9 toggle pin0, R10 capture pin1 still");
    rd(7,  16'h0001, "R9 wrap to zero");
    // R8 fast clear on counter access
    wr(0, 16'h0004);
    wr(9, 16'h0001);
    rd(9, 16'h0001, "R6 fast ignores ovf w1c");
    rd(7, 16'h0001, "R8 counter read");
    rd(9, 16'h0000, "R8 counter read cleared ovf");
    // R11 toggle beats forced clear
    wr(0, 16'h0000);
    wr(4, 16'h0002);
    wr(7, 16'hFFFF);
    wr(0, 16'h0001);
    wr(2, 16'h0001);
    wr(0, 16'h0000);
    rd(10, 16'h0001, "R11 tov over force");
    // R11 override beats toggle
    wr(23, 16'h8000);
    wr(18, 16'h8000);
    wr(1, 16'h0085);
    wr(5, 16'h0005);
    wr(6, 16'h0005);
    wr(7, 16'hFFFF);
    wr(0, 16'h0001);
    wr(2, 16'h0080);
    wr(0, 16'h0000);
    rd(10, 16'h0005, "R11 override over tov");
    // R12 capture edge with same-cycle fast read of ch1
    wr(0, 16'h0004);
    cap = 8'h00;
    idle(1);
    cap = 8'h02;
    rd(17, 16'h1234, "R12 read during capture");
    rd(8,  16'h0002, "R12 set wins over clear");
    idle(2);
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: act=%0d pending exp=0", q_exp.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule